// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Turnaround Sequencer

This block runs a local bus on which one set of lines carries both the address and the data. Every access opens with an address phase that the controller drives. One or more data beats follow, either driven by the controller (write) or by the external device (read). The controller steers an external bus transceiver through a direction output and tristates its own pads through an output enable. Wherever the driver of the lines changes from the device back to the controller, it inserts idle turnaround cycles so the two sides never drive at once.

A client hands over single, burst and read-modify-write accesses through a valid/ready request port. It supplies write data beat by beat against a per-beat acknowledge and receives each read beat as a one-cycle valid pulse. A 2-bit hold setting lengthens the turnaround after read data for devices that are slow to release the lines. Transitions that keep the same driver, such as write beat to write beat, address to write data, or write to the next address, take no idle cycle.

States: IDLE (parked, controller driving), ADDR (address on the lines), RDATA (device drives one read beat), TURN (nobody drives, transceiver pointed outward), WDATA (controller drives one write beat). Transitions: IDLE→ADDR on an accepted request; ADDR→RDATA for read and read-modify-write, ADDR→WDATA for write; RDATA→RDATA while beats remain, RDATA→TURN after the last read beat; TURN→TURN while hold cycles remain, TURN→WDATA for a read-modify-write, otherwise TURN→ADDR when a request is accepted or TURN→IDLE; WDATA→WDATA while beats remain, WDATA→ADDR when a request is accepted on the last beat, otherwise WDATA→IDLE.

Top module: `muxbus_turn_seq`

## Requirements
- R1: After reset the block is parked: `bus_oe`=1, `xcvr_dir`=1, `beat_ack`=0, `rd_valid`=0, `req_ready`=1.
- R2: The cycle after a request is accepted is a single address cycle with `bus_out` equal to the request address, `bus_oe`=1, `xcvr_dir`=1 and `beat_ack`=0.
- R3: A read (`req_kind`=2'b00) gives `req_beats`+1 consecutive read beat cycles right after the address cycle, each with `xcvr_dir`=0, `bus_oe`=0 and `beat_ack`=1.
- R4: In the cycle after each read beat, `rd_valid` is 1 and `rd_data` holds the value `bus_in` had during that beat.
- R5: After the last read beat come exactly `hold_cfg`+1 turnaround cycles with `xcvr_dir`=1, `bus_oe`=0 and `beat_ack`=0.
- R6: A write (`req_kind`=2'b01) gives `req_beats`+1 consecutive write beat cycles right after the address cycle, each with `bus_oe`=1, `xcvr_dir`=1, `beat_ack`=1 and `bus_out` equal to `wr_data`.
- R7: When a request is presented during the last write beat, its address cycle follows in the next cycle with no idle cycle in between, whatever `hold_cfg` is.
- R8: A read-modify-write (`req_kind`=2'b10) is one read beat, the `hold_cfg`+1 turnaround cycles, then one write beat; `req_beats` has no effect on it.
- R9: `req_ready` is 1 in IDLE, in the last write beat and in the last turnaround cycle of a read; it is 0 in the address cycle, read beats, earlier turnaround cycles and in every turnaround cycle of a read-modify-write.
- R10: `bus_oe` is never 1 while `xcvr_dir` is 0, and never 1 while a device that keeps driving for `hold_cfg` cycles after its last read beat could still be driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| req_addr | input | DW | Address driven in the address cycle |
| req_beats | input | BW | Beat count minus one |
| req_ready | output | 1 | Request accepted at this edge if valid |
| hold_cfg | input | HW | Extra idle cycles after read data |
| wr_data | input | DW | Write data for the current write beat |
| beat_ack | output | 1 | A data beat completes this cycle |
| bus_out | output | DW | Value driven onto the shared lines |
| bus_oe | output | 1 | Pad output enable |
| bus_in | input | DW | Value seen on the shared lines |
| xcvr_dir | output | 1 | Transceiver direction, 1 outward, 0 inward |
| rd_data | output | DW | Captured read beat |
| rd_valid | output | 1 | `rd_data` is new this cycle |

## Verification
The bench sweeps all three access kinds across every beat count from one to four and every hold setting from zero to three, checking each phase cycle by cycle against a timeline computed from the request. Separating these patterns distinguishes an off-by-one in the burst length from one in the turnaround length, and shows that the hold setting stretches only read endings. Chained requests (write into read, read into write, read-modify-write into write) show that same-driver transitions take no idle cycle while read endings still do. A device model that keeps driving for the hold count after each read beat flags any cycle in which both sides would drive.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_RDATA,
        S_TURN,
        S_WDATA
    } mbt_state_t;

    typedef enum logic [1:0] {
        K_READ  = 2'b00,
        K_WRITE = 2'b01,
        K_RMW   = 2'b10,
        K_RSVD  = 2'b11
    } mbt_kind_t;

endpackage

// File: rtl/mbt_beat_ctr.sv
module mbt_beat_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && remain != '0)
            remain <= remain - 1'b1;
    end

    assign last = (remain == '0);
endmodule

// File: rtl/mbt_turn_timer.sv
module mbt_turn_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] hold,
    output logic         expired
);
    logic [W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left <= '0;
        else if (start)
            left <= hold;
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign expired = (left == '0);
endmodule

// File: rtl/mbt_rd_capture.sv
module mbt_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= sample;
            if (sample)
                dout <= din;
        end
    end
endmodule

// File: rtl/muxbus_turn_seq.sv
module muxbus_turn_seq
    import mbt_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 2,
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [DW-1:0] req_addr,
    input  logic [BW-1:0] req_beats,
    output logic          req_ready,
    input  logic [HW-1:0] hold_cfg,
    input  logic [DW-1:0] wr_data,
    output logic          beat_ack,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_in,
    output logic          xcvr_dir,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam logic [BW-1:0] ONE_BEAT = '0;

    mbt_state_t    state, nxt;
    mbt_kind_t     kind_q;
    logic [DW-1:0] addr_q;
    logic          accept;
    logic          last_beat;
    logic          turn_done;
    logic          turn_start;
    logic          in_data;
    logic [BW-1:0] beat_load;
    mbt_kind_t     req_kind_e;

    assign req_kind_e = mbt_kind_t'(req_kind);
    assign accept     = req_valid && req_ready;
    assign in_data    = (state == S_RDATA) || (state == S_WDATA);
    assign turn_start = (state == S_RDATA) && last_beat;
    assign beat_load  = (req_kind_e == K_RMW) ? ONE_BEAT : req_beats;

    mbt_beat_ctr #(.W(BW)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (beat_load),
        .dec      (in_data),
        .last     (last_beat)
    );

    mbt_turn_timer #(.W(HW)) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (turn_start),
        .hold    (hold_cfg),
        .expired (turn_done)
    );

    mbt_rd_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (state == S_RDATA),
        .din    (bus_in),
        .dout   (rd_data),
        .valid  (rd_valid)
    );

    // request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_READ;
            addr_q <= '0;
        end else if (accept) begin
            kind_q <= req_kind_e;
            addr_q <= req_addr;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:
                if (req_valid) nxt = S_ADDR;
            S_ADDR:
                nxt = (kind_q == K_WRITE) ? S_WDATA : S_RDATA;
            S_RDATA:
                if (last_beat) nxt = S_TURN;
            S_TURN:
                if (turn_done) begin
                    if (kind_q == K_RMW) nxt = S_WDATA;
                    else if (req_valid)  nxt = S_ADDR;
                    else                 nxt = S_IDLE;
                end
            S_WDATA:
                if (last_beat) nxt = req_valid ? S_ADDR : S_IDLE;
            default:
                nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        beat_ack  = 1'b0;
        bus_out   = '0;
        bus_oe    = 1'b1;
        xcvr_dir  = 1'b1;
        unique case (state)
            S_IDLE: req_ready = 1'b1;
            S_ADDR: bus_out = addr_q;
            S_RDATA: begin
                beat_ack = 1'b1;
                bus_oe   = 1'b0;
                xcvr_dir = 1'b0;
            end
            S_TURN: begin
                bus_oe    = 1'b0;
                req_ready = turn_done && (kind_q != K_RMW);
            end
            S_WDATA: begin
                beat_ack  = 1'b1;
                bus_out   = wr_data;
                req_ready = last_beat;
            end
            default: ;
        endcase
    end

    // R10
    oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> xcvr_dir);

    // R10
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_dir) |-> !bus_oe);

    // R3
    burst_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDATA && !last_beat) |=> (state == S_RDATA));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDATA) |=> rd_valid);

    // R5
    turn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TURN && !turn_done) |=> (state == S_TURN && !bus_oe));

    // R9
    accept_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (state == S_ADDR));
endmodule

// File: tb/muxbus_turn_seq_test.sv
module muxbus_turn_seq_test;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int HW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [DW-1:0] req_addr = '0;
    logic [BW-1:0] req_beats = '0;
    logic          req_ready;
    logic [HW-1:0] hold_cfg = '0;
    logic [DW-1:0] wr_data = '0;
    logic          beat_ack;
    logic [DW-1:0] bus_out;
    logic          bus_oe;
    logic [DW-1:0] bus_in = '0;
    logic          xcvr_dir;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    int n_chk = 0;
    int n_bad = 0;
    int contention = 0;
    int linger = 0;
    int linger_left = 0;

    always #5 clk = ~clk;

    muxbus_turn_seq #(.DW(DW), .BW(BW), .HW(HW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_beats(req_beats), .req_ready(req_ready),
        .hold_cfg(hold_cfg), .wr_data(wr_data), .beat_ack(beat_ack),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .xcvr_dir(xcvr_dir), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // device model: drives while pointed inward, then lingers
    always @(negedge clk) begin
        if (rst_n) begin
            logic drv;
            if (!xcvr_dir) begin
                drv = 1'b1;
                linger_left = linger;
            end else if (linger_left > 0) begin
                drv = 1'b1;
                linger_left = linger_left - 1;
            end else begin
                drv = 1'b0;
            end
            if (drv && bus_oe) contention = contention + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] rpat(input logic [DW-1:0] a, input int b);
        return a + 16'h5A00 + DW'(b * 7);
    endfunction

    function automatic logic [DW-1:0] wpat(input logic [DW-1:0] a, input int b);
        return ~a + DW'(b * 3);
    endfunction

    task automatic issue(input logic [1:0] k, input logic [BW-1:0] nb, input logic [DW-1:0] a);
        req_kind  = k;
        req_beats = nb;
        req_addr  = a;
        req_valid = 1'b1;
    endtask

    // walk one access from its address cycle to its final cycle
    task automatic run_txn(input logic [1:0] k, input int nb, input int h, input logic [DW-1:0] a,
                           input bit chain, input logic [1:0] nk, input logic [BW-1:0] nnb,
                           input logic [DW-1:0] na);
        int nrd;
        int nwr;
        nrd = (k == 2'b01) ? 0 : ((k == 2'b10) ? 1 : nb + 1);
        nwr = (k == 2'b01) ? nb + 1 : ((k == 2'b10) ? 1 : 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 addr bus_out", 32'(bus_out), 32'(a));
        chk("R2 addr oe/dir/ack", {29'd0, bus_oe, xcvr_dir, beat_ack}, 32'b110);
        chk("R9 ready low in addr", 32'(req_ready), 32'd0);
        wr_data = wpat(a, 0);
        for (int b = 0; b < nrd; b++) begin
            @(negedge clk);
            chk((k == 2'b10) ? "R8 rmw read beat" : "R3 read beat oe/dir/ack",
                {29'd0, bus_oe, xcvr_dir, beat_ack}, 32'b001);
            if (b > 0) begin
                chk("R4 rd_valid", 32'(rd_valid), 32'd1);
                chk("R4 rd_data", 32'(rd_data), 32'(rpat(a, b - 1)));
            end
            bus_in = rpat(a, b);
        end
        if (nrd > 0) begin
            for (int t = 0; t <= h; t++) begin
                @(negedge clk);
                chk("R5 turn oe/dir/ack", {29'd0, bus_oe, xcvr_dir, beat_ack}, 32'b010);
                if (t == 0) begin
                    chk("R4 last rd_valid", 32'(rd_valid), 32'd1);
                    chk("R4 last rd_data", 32'(rd_data), 32'(rpat(a, nrd - 1)));
                end
                if (k == 2'b10)
                    chk("R9 ready low in rmw turn", 32'(req_ready), 32'd0);
                else
                    chk("R9 turn ready", 32'(req_ready), (t == h) ? 32'd1 : 32'd0);
                if (t == h && chain && k != 2'b10) issue(nk, nnb, na);
            end
        end
        for (int b = 0; b < nwr; b++) begin
            @(negedge clk);
            chk((k == 2'b10) ? "R8 rmw write beat" : "R6 write beat oe/dir/ack",
                {29'd0, bus_oe, xcvr_dir, beat_ack}, 32'b111);
            chk("R6 write data", 32'(bus_out), 32'(wpat(a, b)));
            chk("R9 ready on write beat", 32'(req_ready), (b == nwr - 1) ? 32'd1 : 32'd0);
            wr_data = wpat(a, b + 1);
            if (b == nwr - 1 && chain) issue(nk, nnb, na);
        end
    endtask

    task automatic expect_idle(input string tag);
        @(negedge clk);
        chk(tag, {28'd0, bus_oe, xcvr_dir, beat_ack, req_ready}, 32'b1101);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 reset oe/dir/ack/ready", {28'd0, bus_oe, xcvr_dir, beat_ack, req_ready}, 32'b1101);
        chk("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 parked after reset", {28'd0, bus_oe, xcvr_dir, beat_ack, req_ready}, 32'b1101);

        // sweep kinds x beats x hold
        for (int k = 0; k < 3; k++) begin
            for (int nb = 0; nb < 4; nb++) begin
                for (int h = 0; h < 4; h++) begin
                    logic [DW-1:0] a;
                    a = DW'(16'h1000 + k * 256 + nb * 16 + h);
                    hold_cfg = HW'(h);
                    linger = h;
                    issue(2'(k), BW'(nb), a);
                    run_txn(2'(k), nb, h, a, 1'b0, 2'b00, '0, '0);
                    expect_idle("R9 idle after access");
                end
            end
        end

        // R7: write with hold 3 chained into read, read chained into write,
        // rmw chained into write; then final idle
        hold_cfg = 2'd3;
        linger = 3;
        issue(2'b01, 2'd1, 16'hA100);
        run_txn(2'b01, 1, 3, 16'hA100, 1'b1, 2'b00, 2'd2, 16'hA200);
        run_txn(2'b00, 2, 3, 16'hA200, 1'b1, 2'b01, 2'd0, 16'hA300);
        hold_cfg = 2'd1;
        linger = 1;
        run_txn(2'b01, 0, 1, 16'hA300, 1'b1, 2'b10, 2'd3, 16'hA400);
        run_txn(2'b10, 3, 1, 16'hA400, 1'b1, 2'b01, 2'd1, 16'hA500);
        run_txn(2'b01, 1, 1, 16'hA500, 1'b0, 2'b00, '0, '0);
        expect_idle("R7 idle after chain");

        chk("R10 no contention with lingering device", 32'(contention), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule